// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block executes the four stack-touching instructions of a small processor: subroutine call, subroutine return, register push and register pop. It owns the stack pointer and the frame pointer and works on a stack that grows toward lower addresses in a word-addressed data memory. It produces the program counter that follows a call or a return, and a write-back value for pop. Every word it moves goes through one shared memory port, one access per cycle. The memory returns read data on the cycle after the request.

A call builds a three-word frame. From the top of the frame down, the words are the return address, the caller's frame pointer and a cleared slot for the return value. A return takes the frame apart in the reverse order. It restores the frame pointer and the program counter. It then copies the return value into the word just below the restored frame pointer, so that the caller finds the result in its own frame.

Before each access, the sequencer checks the address against the memory size. An address outside the memory stops the sequence at once. The processor then halts with a sticky error flag, and nothing further is issued.

Top module: `frame_seq`

## Requirements
- R1: After reset, sp_out and fp_out both equal MEM_WORDS, pc_out is 0, and busy, done, err, wb_en and pc_load are low.
- R2: Push (opcode 0x18) writes reg_val to address sp-1 and leaves sp one lower. done appears on the 2nd clock edge after the start edge.
- R3: Pop (opcode 0x19) reads the word at sp and presents it on wb_data with wb_en during done. sp ends one higher, and done appears on the 3rd edge after start.
- R4: Call (opcode 0x0F) writes three words in this order: pc_in+CALL_LEN at sp-1, then fp at sp-2, then 0 at sp-3. sp ends 3 lower and fp ends at the old sp-2. pc_out becomes pc_in+CALL_LEN+target, with target taken as signed, and pc_load pulses with done on the 4th edge.
- R5: Return (opcode 0x10) reads sp, sp+1 and sp+2 in that order, taking them as the return value, the saved fp and the return address. It then writes the return value to saved fp minus 1. sp ends 3 higher, fp becomes the saved fp, and pc_out becomes the return address with pc_load. done appears on the 5th edge.
- R6: When an access would use an address of MEM_WORDS or more (including wrap-around below 0), that access is not issued. err rises and stays high until reset, and done pulses on the next cycle. Registers the failing step would have changed keep their values.
- R7: While err is high, start is ignored: busy stays low and no memory access is issued.
- R8: busy is high from the cycle after an accepted start through the done cycle, and done lasts exactly one cycle.
- R9: start with any opcode other than the four above, or start while busy, is ignored. No access is issued and sp/fp do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin the instruction on opcode |
| opcode | input | 8 | Instruction code |
| pc_in | input | DATA_W | Address of the current instruction |
| target | input | DATA_W | Signed pc-relative call offset |
| reg_val | input | DATA_W | Register value for push |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sticky error halt |
| pc_out | output | DATA_W | New program counter |
| pc_load | output | 1 | pc_out valid (with done) |
| wb_en | output | 1 | Pop result valid (with done) |
| wb_data | output | DATA_W | Pop result |
| sp_out | output | DATA_W | Stack pointer |
| fp_out | output | DATA_W | Frame pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, one cycle after request |

## Verification
The bench interleaves pushes and pops and expects the results in LIFO order. A design that decremented after the store, or incremented before the load, would return neighbouring words. A call followed by a return is checked word by word against a log of memory traffic. A swapped frame order or a return value written at the stale frame pointer shows up there as wrong addresses or data. Three out-of-range cases are driven: a pop from an empty stack, a push into a full stack that wraps below address 0, and a return whose restored frame pointer is 0. A design that checked only sp, or that committed before checking, would issue a stray write or update fp and pc.

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64,
  parameter int CALL_LEN  = 2,
  localparam int ADDR_W   = $clog2(MEM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0] target,
  input  logic [DATA_W-1:0] reg_val,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] pc_out,
  output logic              pc_load,
  output logic              wb_en,
  output logic [DATA_W-1:0] wb_data,
  output logic [DATA_W-1:0] sp_out,
  output logic [DATA_W-1:0] fp_out,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam logic [7:0] OP_CALL = 8'h0F;
  localparam logic [7:0] OP_RET  = 8'h10;
  localparam logic [7:0] OP_PUSH = 8'h18;
  localparam logic [7:0] OP_POP  = 8'h19;
  localparam logic [DATA_W-1:0] TOP = DATA_W'(MEM_WORDS);

  typedef enum logic [3:0] {
    S_IDLE, S_C_RET, S_C_FP, S_C_ZERO,
    S_R_VAL, S_R_FP, S_R_RA, S_R_WB,
    S_PUSH, S_POP, S_POP_WB, S_FIN
  } state_t;

  state_t            state;
  logic [DATA_W-1:0] sp, fp, pc_r, ret_pc, tgt_r, val_r, rv_r, sfp_r, wb_r;
  logic              err_r, ok_r, is_pop_r, is_pc_r;

  logic              acc, wr, in_rng;
  logic [DATA_W-1:0] addr, wd;

  always_comb begin
    acc  = 1'b0;
    wr   = 1'b0;
    addr = sp - 1'b1;
    wd   = '0;
    case (state)
      S_C_RET:  begin acc = 1'b1; wr = 1'b1; wd = ret_pc; end
      S_C_FP:   begin acc = 1'b1; wr = 1'b1; wd = fp; end
      S_C_ZERO: begin acc = 1'b1; wr = 1'b1; end
      S_PUSH:   begin acc = 1'b1; wr = 1'b1; wd = val_r; end
      S_R_VAL, S_R_FP, S_R_RA, S_POP: begin acc = 1'b1; addr = sp; end
      S_R_WB:   begin acc = 1'b1; wr = 1'b1; addr = sfp_r - 1'b1; wd = rv_r; end
      default:  ;
    endcase
  end

  assign in_rng    = addr < TOP;
  assign mem_req   = acc && in_rng;
  assign mem_we    = acc && wr && in_rng;
  assign mem_addr  = addr[ADDR_W-1:0];
  assign mem_wdata = wd;

  wire fault  = acc && !in_rng;
  wire op_ok  = (opcode == OP_CALL) || (opcode == OP_RET) ||
                (opcode == OP_PUSH) || (opcode == OP_POP);
  wire accept = (state == S_IDLE) && start && !err_r && op_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      sp       <= TOP;
      fp       <= TOP;
      pc_r     <= '0;
      ret_pc   <= '0;
      tgt_r    <= '0;
      val_r    <= '0;
      rv_r     <= '0;
      sfp_r    <= '0;
      wb_r     <= '0;
      err_r    <= 1'b0;
      ok_r     <= 1'b0;
      is_pop_r <= 1'b0;
      is_pc_r  <= 1'b0;
    end else if (fault) begin
      err_r <= 1'b1;
      ok_r  <= 1'b0;
      state <= S_FIN;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          ret_pc   <= pc_in + DATA_W'(CALL_LEN);
          tgt_r    <= target;
          val_r    <= reg_val;
          ok_r     <= 1'b1;
          is_pop_r <= opcode == OP_POP;
          is_pc_r  <= (opcode == OP_CALL) || (opcode == OP_RET);
          case (opcode)
            OP_CALL: state <= S_C_RET;
            OP_RET:  state <= S_R_VAL;
            OP_PUSH: state <= S_PUSH;
            default: state <= S_POP;
          endcase
        end
        S_C_RET: begin
          sp    <= sp - 1'b1;
          pc_r  <= ret_pc + tgt_r;
          state <= S_C_FP;
        end
        S_C_FP: begin
          sp    <= sp - 1'b1;
          fp    <= sp - 1'b1;
          state <= S_C_ZERO;
        end
        S_C_ZERO: begin
          sp    <= sp - 1'b1;
          state <= S_FIN;
        end
        S_R_VAL: begin
          sp    <= sp + 1'b1;
          state <= S_R_FP;
        end
        S_R_FP: begin
          rv_r  <= mem_rdata;
          sp    <= sp + 1'b1;
          state <= S_R_RA;
        end
        S_R_RA: begin
          sfp_r <= mem_rdata;
          sp    <= sp + 1'b1;
          state <= S_R_WB;
        end
        S_R_WB: begin
          fp    <= sfp_r;
          pc_r  <= mem_rdata;
          state <= S_FIN;
        end
        S_PUSH: begin
          sp    <= sp - 1'b1;
          state <= S_FIN;
        end
        S_POP: begin
          sp    <= sp + 1'b1;
          state <= S_POP_WB;
        end
        S_POP_WB: begin
          wb_r  <= mem_rdata;
          state <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = state != S_IDLE;
  assign done    = state == S_FIN;
  assign err     = err_r;
  assign pc_out  = pc_r;
  assign pc_load = done && is_pc_r && ok_r;
  assign wb_en   = done && is_pop_r && ok_r;
  assign wb_data = wb_r;
  assign sp_out  = sp;
  assign fp_out  = fp;
endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
  parameter int DATA_W    = 32,
  parameter int MEM_WORDS = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              mem_req,
  input logic [DATA_W-1:0] sp_out
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);               // R8
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);               // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err);                   // R6
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n) err |-> !mem_req);              // R7
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req);        // R9
  AST_IDLE_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(sp_out));   // R9
  AST_SP_BOUND: assert property (@(posedge clk) disable iff (!rst_n) sp_out <= DATA_W'(MEM_WORDS));    // R6
endmodule

bind frame_seq frame_seq_chk #(.DATA_W(DATA_W), .MEM_WORDS(MEM_WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .mem_req(mem_req), .sp_out(sp_out)
);

// File: tb/frame_seq_tb.sv
module frame_seq_tb_top;
  localparam int DW = 32;
  localparam int MW = 64;
  localparam int AW = $clog2(MW);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    opcode = 8'h00;
  logic [DW-1:0] pc_in = '0, target = '0, reg_val = '0;
  logic          busy, done, err, pc_load, wb_en, mem_req, mem_we;
  logic [DW-1:0] pc_out, wb_data, sp_out, fp_out, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  frame_seq #(.DATA_W(DW), .MEM_WORDS(MW), .CALL_LEN(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .pc_in(pc_in),
    .target(target), .reg_val(reg_val), .busy(busy), .done(done), .err(err),
    .pc_out(pc_out), .pc_load(pc_load), .wb_en(wb_en), .wb_data(wb_data),
    .sp_out(sp_out), .fp_out(fp_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] mem [MW];
  int            nacc;
  logic          lw [16];
  logic [DW-1:0] la [16], ld [16];

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
      if (nacc < 16) begin
        lw[nacc] <= mem_we;
        la[nacc] <= DW'(mem_addr);
        ld[nacc] <= mem_we ? mem_wdata : mem[mem_addr];
      end
      nacc <= nacc + 1;
    end
  end

  int checks = 0, errors = 0;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic [7:0] op, input logic [DW-1:0] v, input logic [DW-1:0] pcv,
                     input logic [DW-1:0] tg, output int cyc);
    nacc = 0;
    opcode = op; reg_val = v; pc_in = pcv; target = tg;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 50) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // each entry: opcode, reg_val, expected sp, expected pop data
  localparam logic [103:0] VEC [8] = '{
    {8'h18, 32'd11, 32'd63, 32'd0},
    {8'h18, 32'd22, 32'd62, 32'd0},
    {8'h18, 32'd33, 32'd61, 32'd0},
    {8'h19, 32'd0,  32'd62, 32'd33},
    {8'h18, 32'd44, 32'd61, 32'd0},
    {8'h19, 32'd0,  32'd62, 32'd44},
    {8'h19, 32'd0,  32'd63, 32'd22},
    {8'h19, 32'd0,  32'd64, 32'd11}
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    nacc = 0;
    for (int i = 0; i < MW; i++) mem[i] = '0;
    do_reset();
    @(negedge clk);
    chk("R1 sp", sp_out, 64);
    chk("R1 fp", fp_out, 64);
    chk("R1 pc", pc_out, 0);
    chk("R1 flags", {busy, done, err, wb_en, pc_load}, 0);

    for (int i = 0; i < 8; i++) begin
      run(VEC[i][103:96], VEC[i][95:64], 0, 0, cyc);
      if (VEC[i][103:96] == 8'h18) begin
        chk("R2 push sp", sp_out, VEC[i][63:32]);
        chk("R2 push cycles", cyc, 2);
        chk("R2 push write", {31'd0, lw[0]} + la[0] * 2 + ld[0] * 256,
            1 + VEC[i][63:32] * 2 + VEC[i][95:64] * 256);
      end else begin
        chk("R3 pop data", wb_data, VEC[i][31:0]);
        chk("R3 pop wb_en", wb_en, 1);
        chk("R3 pop sp", sp_out, VEC[i][63:32]);
        chk("R3 pop cycles", cyc, 3);
      end
      chk("R8 busy at done", busy, 1);
      @(negedge clk);
      chk("R8 done one cycle", {busy, done}, 0);
    end

    run(8'h0F, 0, 100, -32'sd30, cyc);
    chk("R4 cycles", cyc, 4);
    chk("R4 writes", nacc, 3);
    chk("R4 w0 addr", la[0], 63); chk("R4 w0 data", ld[0], 102);
    chk("R4 w1 addr", la[1], 62); chk("R4 w1 data", ld[1], 64);
    chk("R4 w2 addr", la[2], 61); chk("R4 w2 data", ld[2], 0);
    chk("R4 all writes", {lw[0], lw[1], lw[2]}, 3'b111);
    chk("R4 sp", sp_out, 61);
    chk("R4 fp", fp_out, 62);
    chk("R4 pc", pc_out, 72);
    chk("R4 pc_load", pc_load, 1);
    @(negedge clk);

    mem[61] = 555;
    run(8'h10, 0, 0, 0, cyc);
    chk("R5 cycles", cyc, 5);
    chk("R5 accesses", nacc, 4);
    chk("R5 read order", la[0] * 10000 + la[1] * 100 + la[2], 616263);
    chk("R5 rv write addr", la[3], 63);
    chk("R5 rv write data", ld[3], 555);
    chk("R5 rv write en", lw[3], 1);
    chk("R5 sp", sp_out, 64);
    chk("R5 fp", fp_out, 64);
    chk("R5 pc", pc_out, 102);
    chk("R5 pc_load", pc_load, 1);
    @(negedge clk);

    opcode = 8'h11; start = 1'b1; nacc = 0;
    repeat (2) @(negedge clk);
    start = 1'b0;
    chk("R9 bad opcode busy", busy, 0);
    chk("R9 bad opcode access", nacc, 0);
    chk("R9 bad opcode sp", sp_out, 64);

    run(8'h18, 7, 0, 0, cyc);
    opcode = 8'h18; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9 start while busy", sp_out, 63);
    chk("R9 start while busy idle", busy, 0);

    do_reset();
    run(8'h19, 0, 0, 0, cyc);
    chk("R6 empty pop access", nacc, 0);
    chk("R6 empty pop err", err, 1);
    chk("R6 empty pop wb_en", wb_en, 0);
    chk("R6 empty pop sp", sp_out, 64);
    chk("R6 cycles", cyc, 2);
    @(negedge clk);
    opcode = 8'h18; start = 1'b1; nacc = 0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    chk("R7 start ignored busy", busy, 0);
    chk("R7 start ignored access", nacc, 0);
    chk("R7 err held", err, 1);

    do_reset();
    for (int i = 0; i < MW; i++) begin
      run(8'h18, i, 0, 0, cyc);
      @(negedge clk);
    end
    chk("R2 full stack sp", sp_out, 0);
    chk("R2 full stack no err", err, 0);
    run(8'h18, 99, 0, 0, cyc);
    chk("R6 overflow access", nacc, 0);
    chk("R6 overflow err", err, 1);
    chk("R6 overflow sp", sp_out, 0);

    do_reset();
    run(8'h18, 5, 0, 0, cyc); @(negedge clk);
    run(8'h18, 0, 0, 0, cyc); @(negedge clk);
    run(8'h18, 9, 0, 0, cyc); @(negedge clk);
    run(8'h10, 0, 0, 0, cyc);
    chk("R6 bad fp accesses", nacc, 3);
    chk("R6 bad fp no write", lw[0] | lw[1] | lw[2], 0);
    chk("R6 bad fp err", err, 1);
    chk("R6 bad fp keeps fp", fp_out, 64);
    chk("R6 bad fp keeps pc", pc_out, 0);
    chk("R6 bad fp pc_load", pc_load, 0);
    chk("R6 bad fp sp", sp_out, 64);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule